// File: doc/BRIEF.md
# GPIO Interrupt Router with Trigger Conditioning

This block takes a wide vector of asynchronous GPIO pad inputs and steers any eight of them onto eight interrupt channel outputs. Each channel holds an 8-bit pad index chosen by software. The selected pad then passes through a per-channel trigger stage, so that the interrupt controller downstream only ever sees two forms: an active-high level, or a one-clock rising pulse. The trigger stage can pass a level straight through, pass it inverted, detect rising edges, detect falling edges, or detect every transition.

Software programs the block through a plain 32-bit register port. It has a write strobe, a read strobe, a byte address and separate write and read data buses. The port is not a stream. A write or read is accepted in any cycle it is strobed, and there is no back-pressure or wait state. Read data is combinational from the address while the read strobe is high, and it is zero otherwise. All pads pass through a two-flop synchronizer before selection. If software changes a channel's index or mode, the change itself never produces an interrupt.

Top module: `gpio_irq_router`

## Requirements
- R1: While reset is low and right after it is released, every register reads zero and all eight channel outputs are low.
- R2: The pad index of channel c is an 8-bit field at bit (c mod 4)*8. Channels 0..3 are at byte address 0x04 and channels 4..7 at 0x08. The channel follows pad[index], and a written index reads back unchanged.
- R3: The mode register at 0x00 has three fields. Bits [7:0] hold the edge-mode enable of channels 7..0, bits [15:8] the any-edge enable, and bits [23:16] the invert enable. Bits [31:24] always read zero.
- R4: In level mode (edge-mode and any-edge bits clear, invert clear), the channel output equals the selected pad. A pad change first shows on the output on the third rising clock edge after it is applied.
- R5: In level mode with the invert bit set, the output is the complement of the selected pad, so a low pad gives a high output.
- R6: With edge mode set and invert clear, each rising transition of the selected pad gives exactly one clock cycle of high output. A falling transition gives none.
- R7: With edge mode and invert both set, each falling transition gives one one-cycle pulse. A rising transition gives none.
- R8: With the any-edge bit set, every transition of the selected pad gives a one-cycle pulse, whatever the edge-mode and invert bits hold.
- R9: A change to a channel's index or mode bits never produces a pulse in the cycle that follows the change.
- R10: The register at 0x0C holds eight 4-bit filter-select fields, with channel c at bit c*4. All 32 bits are writable and read back, and the register has no effect on any output.
- R11: An address with any bit at or above bit 4 set reads zero, and a write to it changes no register. Address bits [1:0] are ignored. The read data is zero whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (6) | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero when reg_rd is low |
| pad_in | input | NUM_PADS (256) | Asynchronous pad inputs |
| chan_irq | output | 8 | Conditioned active-high channel outputs |

## Verification
A counted directed case pins the three-edge latency of a level, so a missing or extra synchronizer stage stands out. A sequence of directed cases follows. Rising and falling pulses are driven on one channel across the edge, inverted-edge and any-edge modes, and the pulse counts tell a rising-edge detector from a falling-edge or any-edge detector. An index switch onto a pad that is already high separates a design that stores the history correctly from one that fires on reconfiguration. A seeded random phase then runs all eight channels at once against a cycle model. It toggles a handful of pads and rewrites the registers at random, unmapped addresses included. This shows that per-channel fields do not bleed into each other and that filter-select writes have no effect on the outputs.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int NCH    = 8;
  localparam int IDX_W  = 8;
  localparam int FILT_W = 4;
  localparam int DATA_W = 32;
  localparam int PER_WORD = DATA_W / IDX_W;

  localparam logic [1:0] W_MODE = 2'd0;
  localparam logic [1:0] W_SELA = 2'd1;
  localparam logic [1:0] W_SELB = 2'd2;
  localparam logic [1:0] W_FILT = 2'd3;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             both;
    logic             edge_en;
    logic             inv;
  } chan_cfg_t;
endpackage

// File: rtl/gir_sync.sv
module gir_sync #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gir_regs.sv
module gir_regs
  import gir_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output chan_cfg_t [NCH-1:0]  cfg
);
  localparam int TOP_W = ADDR_W - 4;

  logic [NCH-1:0]    edge_r, both_r, inv_r;
  logic [DATA_W-1:0] sela_r, selb_r, filt_r;
  logic              hit;
  logic [1:0]        word;
  logic [DATA_W-1:0] rd_val;

  assign hit  = (addr[ADDR_W-1 -: TOP_W] == '0);
  assign word = addr[3:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_r <= '0;
      both_r <= '0;
      inv_r  <= '0;
      sela_r <= '0;
      selb_r <= '0;
      filt_r <= '0;
    end else if (wr && hit) begin
      case (word)
        W_MODE: begin
          edge_r <= wdata[NCH-1:0];
          both_r <= wdata[2*NCH-1:NCH];
          inv_r  <= wdata[3*NCH-1:2*NCH];
        end
        W_SELA:  sela_r <= wdata;
        W_SELB:  selb_r <= wdata;
        default: filt_r <= wdata;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit) begin
      case (word)
        W_MODE:  rd_val = {{(DATA_W-3*NCH){1'b0}}, inv_r, both_r, edge_r};
        W_SELA:  rd_val = sela_r;
        W_SELB:  rd_val = selb_r;
        default: rd_val = filt_r;
      endcase
    end
    rdata = rd ? rd_val : '0;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cfg
    if (c < PER_WORD) begin : g_a
      assign cfg[c].idx = sela_r[(c % PER_WORD)*IDX_W +: IDX_W];
    end else begin : g_b
      assign cfg[c].idx = selb_r[(c % PER_WORD)*IDX_W +: IDX_W];
    end
    assign cfg[c].both    = both_r[c];
    assign cfg[c].edge_en = edge_r[c];
    assign cfg[c].inv     = inv_r[c];
  end

  // R2: an index written to the low select word reaches channel 0
  a_r2_sel_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit && word == W_SELA) |=> cfg[0].idx == $past(wdata[IDX_W-1:0]));

  // R11: writes outside the mapped window leave every channel setting alone
  a_r11_unmapped_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit) |=> $stable(cfg));
endmodule

// File: rtl/gir_chan.sv
module gir_chan
  import gir_pkg::*;
#(
  parameter int NUM_PADS = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pads,
  input  chan_cfg_t           cfg,
  output logic                irq
);
  chan_cfg_t cfg_q;
  logic      sel, smp, prev_q, prev_eff, chg, nxt;

  always_comb begin
    sel = 1'b0;
    if (int'(cfg.idx) < NUM_PADS) sel = pads[cfg.idx];
  end

  assign smp      = sel ^ (cfg.inv & ~cfg.both);
  assign chg      = (cfg != cfg_q);
  assign prev_eff = chg ? smp : prev_q;

  always_comb begin
    if (cfg.both)         nxt = smp ^ prev_eff;
    else if (cfg.edge_en) nxt = smp & ~prev_eff;
    else                  nxt = smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      prev_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      irq    <= nxt;
      prev_q <= smp;
      cfg_q  <= cfg;
    end
  end

  // R4/R5: in level mode the output tracks the selected pad, inverted on request
  a_r4_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.edge_en && !cfg.both && !chg) |=> irq == $past(sel ^ cfg.inv));

  // R6: a single-edge pulse lasts exactly one cycle while the settings hold
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && cfg_q.edge_en && !cfg_q.both && !chg) |=> !irq);

  // R9: reconfiguring into an edge mode never fires by itself
  a_r9_no_false_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && (cfg.edge_en || cfg.both)) |=> !irq);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gir_pkg::*;
#(
  parameter int NUM_PADS = 256,
  parameter int ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NCH-1:0]      chan_irq
);
  chan_cfg_t [NCH-1:0] cfg;
  logic [NUM_PADS-1:0] pad_s;

  gir_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .rd    (reg_rd),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  gir_sync #(.W(NUM_PADS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    gir_chan #(.NUM_PADS(NUM_PADS)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .pads  (pad_s),
      .cfg   (cfg[c]),
      .irq   (chan_irq[c])
    );
  end
endmodule

// File: tb/gpio_irq_router_bench.sv
`timescale 1ns/1ps
module gpio_irq_router_bench;
  localparam int NP = 256;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad = '0;
  logic [7:0]    irq;

  int n_run = 0, n_fail = 0;

  // cycle model state, built from the requirements
  logic [NP-1:0] m1 = '0, m2 = '0;
  logic [7:0]    mprev = '0, mexp = '0;
  logic [31:0]   sh_mode = '0, sh_sela = '0, sh_selb = '0, sh_filt = '0;
  logic [10:0]   mcfgq [8];

  always #2.5 clk = ~clk;

  gpio_irq_router u_gpio_irq_router (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .pad_in(pad), .chan_irq(irq)
  );

  function automatic logic [10:0] cfg_of(int c);
    logic [7:0] ix;
    ix = (c < 4) ? sh_sela[(c%4)*8 +: 8] : sh_selb[(c%4)*8 +: 8];
    return {ix, sh_mode[8+c], sh_mode[c], sh_mode[16+c]};
  endfunction

  function automatic logic [31:0] reg_exp(logic [AW-1:0] a);
    if (a[AW-1:4] != '0) return 32'h0;
    case (a[3:2])
      2'd0: return sh_mode;
      2'd1: return sh_sela;
      2'd2: return sh_selb;
      default: return sh_filt;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [7:0] nexp, nprev;
    for (int c = 0; c < 8; c++) begin
      logic [10:0] cf;
      logic s, pe;
      cf = cfg_of(c);
      s  = m2[cf[10:3]] ^ (cf[0] & ~cf[2]);
      pe = (cf != mcfgq[c]) ? s : mprev[c];
      nprev[c] = s;
      if (cf[2])      nexp[c] = s ^ pe;
      else if (cf[1]) nexp[c] = s & ~pe;
      else            nexp[c] = s;
      mcfgq[c] = cf;
    end
    mexp = nexp; mprev = nprev;
    m2 = m1; m1 = pad;
    if (wr && addr[AW-1:4] == '0) begin
      case (addr[3:2])
        2'd0: sh_mode = wdata & 32'h00FF_FFFF;
        2'd1: sh_sela = wdata;
        2'd2: sh_selb = wdata;
        default: sh_filt = wdata;
      endcase
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cmp_irq(input string tag);
    check(irq == mexp, tag, {24'h0, irq}, {24'h0, mexp});
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0;
    cmp_irq(tag);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string tag);
    addr = a; rd = 1'b1; #1;
    check(rdata == reg_exp(a), tag, rdata, reg_exp(a));
    rd = 1'b0; #1;
    check(rdata == 32'h0, {tag, " idle"}, rdata, 32'h0);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin tick(); cmp_irq(tag); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int pulses;
    for (int c = 0; c < 8; c++) mcfgq[c] = '0;
    process::self().srandom(32'd1234);
    repeat (4) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 16; a += 4) rd_chk(AW'(a), "R1");
    check(irq == 8'h0, "R1 irq in reset", {24'h0, irq}, 32'h0);
    rst_n = 1'b1;
    run(2, "R1");

    // R4: latency of a level on channel 0 (index 0)
    pad[0] = 1'b1;
    tick(); check(irq[0] == 1'b0, "R4 edge1", {31'h0, irq[0]}, 32'h0);
    tick(); check(irq[0] == 1'b0, "R4 edge2", {31'h0, irq[0]}, 32'h0);
    tick(); check(irq[0] == 1'b1, "R4 edge3", {31'h0, irq[0]}, 32'h1);
    pad[0] = 1'b0; run(4, "R4");

    // R3/R10/R2 readback
    wr_reg(6'h00, 32'hFFFF_FFFF, "R3"); rd_chk(6'h00, "R3 upper zero");
    wr_reg(6'h00, 32'h0, "R3");
    wr_reg(6'h0C, 32'hA5C3_961E, "R10"); rd_chk(6'h0C, "R10");
    wr_reg(6'h04, 32'h0302_0100, "R2");  wr_reg(6'h08, 32'h0706_0504, "R2");
    rd_chk(6'h04, "R2"); rd_chk(6'h08, "R2");
    // R11: unmapped address and ignored low bits
    wr_reg(6'h10, 32'hFFFF_FFFF, "R11"); rd_chk(6'h10, "R11"); rd_chk(6'h05, "R11");
    rd_chk(6'h04, "R11 no alias");

    // R2: each channel follows its own pad
    pad[7:0] = 8'h5A; run(4, "R2");
    check(irq == 8'h5A, "R2 routing", {24'h0, irq}, 32'h5A);
    // R5: invert all channels
    wr_reg(6'h00, 32'h00FF_0000, "R5"); run(4, "R5");
    check(irq == 8'hA5, "R5 inverted", {24'h0, irq}, 32'hA5);

    // R6: rising pulses on channel 0, one per rise
    wr_reg(6'h00, 32'h0000_0001, "R6"); pad[7:0] = 8'h0; run(4, "R6");
    pulses = 0;
    for (int k = 0; k < 3; k++) begin
      pad[0] = 1'b1; for (int j = 0; j < 5; j++) begin tick(); cmp_irq("R6"); pulses += irq[0]; end
      pad[0] = 1'b0; for (int j = 0; j < 5; j++) begin tick(); cmp_irq("R6"); pulses += irq[0]; end
    end
    check(pulses == 3, "R6 pulse count", 32'(pulses), 32'd3);
    // R7: falling pulses
    wr_reg(6'h00, 32'h0001_0001, "R7"); run(3, "R7");
    pulses = 0;
    for (int k = 0; k < 3; k++) begin
      pad[0] = 1'b1; for (int j = 0; j < 5; j++) begin tick(); cmp_irq("R7"); pulses += irq[0]; end
      pad[0] = 1'b0; for (int j = 0; j < 5; j++) begin tick(); cmp_irq("R7"); pulses += irq[0]; end
    end
    check(pulses == 3, "R7 pulse count", 32'(pulses), 32'd3);
    // R8: any edge, other bits set too
    wr_reg(6'h00, 32'h0001_0101, "R8"); run(3, "R8");
    pulses = 0;
    for (int k = 0; k < 3; k++) begin
      pad[0] = 1'b1; for (int j = 0; j < 5; j++) begin tick(); cmp_irq("R8"); pulses += irq[0]; end
      pad[0] = 1'b0; for (int j = 0; j < 5; j++) begin tick(); cmp_irq("R8"); pulses += irq[0]; end
    end
    check(pulses == 6, "R8 pulse count", 32'(pulses), 32'd6);

    // R9: switch channel 0 onto a high pad while in edge modes
    wr_reg(6'h00, 32'h0000_0001, "R9"); pad[9] = 1'b1; run(4, "R9");
    wr_reg(6'h04, 32'h0302_0109, "R9");
    for (int j = 0; j < 4; j++) begin
      tick(); check(irq[0] == 1'b0, "R9 index change", {31'h0, irq[0]}, 32'h0);
    end
    wr_reg(6'h00, 32'h0000_0100, "R9");
    check(irq[0] == 1'b0, "R9 mode change", {31'h0, irq[0]}, 32'h0);
    run(3, "R9");

    // seeded random phase: R2..R11 against the cycle model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 19);
      pad[15:0] = pad[15:0] ^ 16'($urandom() & $urandom());
      if (r == 0) begin
        addr = AW'($urandom_range(0, 63)); wdata = $urandom();
        if (addr[3:2] inside {2'd1, 2'd2} && $urandom_range(0, 3) != 0) wdata = wdata & 32'h0F0F_0F0F;
        wr = 1'b1; tick(); wr = 1'b0; cmp_irq("R11/R10 rand write");
      end else begin
        tick(); cmp_irq("R4/R5/R6/R7/R8/R9 rand");
      end
      if (r == 1) rd_chk(AW'($urandom_range(0, 63)), "R2/R3/R10/R11 rand read");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule